// File: doc/BRIEF.md
# Button-Started PWM Heating Profile Sequencer

This block drives the gate enable of a heater through a slow pulse-width-modulated waveform. The duty cycle follows a fixed open-loop profile of three phases that step upward, and then the heater switches off. A push button starts the profile from idle. A second press while the profile runs cancels it and drops the heater at once. After the last phase the block returns to idle and the heater stays off until the next press.

Each PWM period has `PWM_SLOTS` slots of `SLOT_TICKS` clock cycles. The enable is high for the first `DUTYn` slots of every period in phase n. Each phase lasts a whole number of PWM periods. With a 50 MHz clock the defaults give a 2 s period, and phase lengths of 90 s, 90 s and 60 s at 30 %, 40 % and 60 % duty. The button is synchronised by two flops and debounced before its rising edge is used.

Top module: `heat_profile_seq`

## Requirements
- R1: While reset is asserted and after it is released, the block is idle: `active_o` = 0, `heat_en_o` = 0, `phase_o` = 0.
- R2: The button level passes through a two-flop synchroniser. A new level is accepted only after `DEB_TICKS` consecutive cycles at that level. A high level applied after the falling clock edge makes `active_o` high at the sampling point `DEB_TICKS`+2 rising edges later. A high pulse shorter than `DEB_TICKS` cycles has no effect.
- R3: Only the rising edge of the debounced button counts as a press. Holding the button past the end of a profile does not start another one.
- R4: Let t be the number of cycles since the first active cycle (t = 0). Then `heat_en_o` = 1 exactly when ((t / `SLOT_TICKS`) mod `PWM_SLOTS`) is less than the current phase's duty value.
- R5: The phases run in order with duties `DUTY1`, `DUTY2` and `DUTY3`. They last `PH1_PERIODS`, `PH2_PERIODS` and `PH3_PERIODS` PWM periods. `phase_o` shows 1, 2 or 3 for the running phase and 0 when idle. Each step is +1, and a profile always begins at 1.
- R6: At the end of the last phase the block goes idle by itself. This happens at t = (sum of phase periods) × `PWM_SLOTS` × `SLOT_TICKS`. It then stays off.
- R7: A press during a profile cancels it. `active_o` and `heat_en_o` are low in the cycle in which that press is accepted.
- R8: `heat_en_o` is never high while `active_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_i | input | 1 | Raw push-button level, asynchronous, high when pressed |
| heat_en_o | output | 1 | Heater gate enable |
| active_o | output | 1 | High while a profile runs |
| phase_o | output | 2 | Running phase 1..3, 0 when idle |

## Verification
The assertions assume only that reset is applied at start. The button may change at any time, because it passes through the synchroniser before any state depends on it. The checks on phase order assume the profile is left only through completion or a press. The stimulus keeps every release at least `DEB_TICKS`+3 cycles before the next intended press, so that each press is accepted as a clean edge. Cancel points are drawn at random from the range in which the accepted press still falls inside the running profile. Deliberately short glitches stay one cycle under the debounce window.

// File: rtl/heat_profile_seq.sv
module heat_profile_seq #(
  parameter int SLOT_TICKS  = 1_000_000,
  parameter int PWM_SLOTS   = 100,
  parameter int DEB_TICKS   = 500_000,
  parameter int PH1_PERIODS = 45,
  parameter int PH2_PERIODS = 45,
  parameter int PH3_PERIODS = 30,
  parameter int DUTY1       = 30,
  parameter int DUTY2       = 40,
  parameter int DUTY3       = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_i,
  output logic       heat_en_o,
  output logic       active_o,
  output logic [1:0] phase_o
);
  localparam int DIV_W  = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam int SLOT_W = (PWM_SLOTS > 1) ? $clog2(PWM_SLOTS) : 1;
  localparam int DEB_W  = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;
  localparam int MAXP01 = (PH1_PERIODS > PH2_PERIODS) ? PH1_PERIODS : PH2_PERIODS;
  localparam int MAXP   = (MAXP01 > PH3_PERIODS) ? MAXP01 : PH3_PERIODS;
  localparam int PER_W  = (MAXP > 1) ? $clog2(MAXP) : 1;

  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(SLOT_TICKS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(PWM_SLOTS - 1);
  localparam logic [DEB_W-1:0]  DEB_LAST  = DEB_W'(DEB_TICKS - 1);
  localparam logic [PER_W-1:0]  LEN1 = PER_W'(PH1_PERIODS - 1);
  localparam logic [PER_W-1:0]  LEN2 = PER_W'(PH2_PERIODS - 1);
  localparam logic [PER_W-1:0]  LEN3 = PER_W'(PH3_PERIODS - 1);
  localparam logic [SLOT_W:0]   D1 = (SLOT_W+1)'(DUTY1);
  localparam logic [SLOT_W:0]   D2 = (SLOT_W+1)'(DUTY2);
  localparam logic [SLOT_W:0]   D3 = (SLOT_W+1)'(DUTY3);

  logic [1:0]        sync_q;
  logic              db_q;
  logic [DEB_W-1:0]  deb_q;
  logic              run_q;
  logic [1:0]        ph_q;
  logic [DIV_W-1:0]  div_q;
  logic [SLOT_W-1:0] slot_q;
  logic [PER_W-1:0]  per_q;

  wire btn_s = sync_q[1];
  wire press = btn_s & ~db_q & (deb_q == DEB_LAST);

  logic [PER_W-1:0] len_sel;
  logic [SLOT_W:0]  duty_sel;
  always_comb begin
    case (ph_q)
      2'd0:    begin len_sel = LEN1; duty_sel = D1; end
      2'd1:    begin len_sel = LEN2; duty_sel = D2; end
      default: begin len_sel = LEN3; duty_sel = D3; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      db_q   <= 1'b0;
      deb_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], btn_i};
      if (btn_s != db_q) begin
        if (deb_q == DEB_LAST) begin
          db_q  <= btn_s;
          deb_q <= '0;
        end else begin
          deb_q <= deb_q + 1'b1;
        end
      end else begin
        deb_q <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ph_q   <= '0;
      div_q  <= '0;
      slot_q <= '0;
      per_q  <= '0;
    end else if (press) begin
      run_q  <= ~run_q;
      ph_q   <= '0;
      div_q  <= '0;
      slot_q <= '0;
      per_q  <= '0;
    end else if (run_q) begin
      if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (slot_q == SLOT_LAST) begin
          slot_q <= '0;
          if (per_q == len_sel) begin
            per_q <= '0;
            if (ph_q == 2'd2) run_q <= 1'b0;
            else              ph_q  <= ph_q + 2'd1;
          end else begin
            per_q <= per_q + 1'b1;
          end
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign active_o  = run_q;
  assign heat_en_o = run_q & ({1'b0, slot_q} < duty_sel);
  assign phase_o   = run_q ? ph_q + 2'd1 : 2'd0;
endmodule

module heat_profile_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       heat_en_o,
  input logic       active_o,
  input logic [1:0] phase_o
);
  a_r8_heat_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    heat_en_o |-> active_o);
  a_r1_idle_phase_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> phase_o == 2'd0);
  a_r5_phase_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && $past(active_o)) |-> (phase_o == $past(phase_o) || phase_o == $past(phase_o) + 2'd1));
  a_r5_start_phase1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> phase_o == 2'd1);
  a_r7_off_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_o) |-> !heat_en_o);
endmodule

bind heat_profile_seq heat_profile_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .heat_en_o(heat_en_o),
  .active_o(active_o), .phase_o(phase_o)
);

// File: tb/heat_profile_seq_tb_top.sv
module heat_profile_seq_tb_top;
  localparam int SLOT = 1, SLOTS = 100, DEB = 4;
  localparam int P1 = 3, P2 = 2, P3 = 2;
  localparam int DU1 = 30, DU2 = 40, DU3 = 60;
  localparam int PER = SLOT * SLOTS;
  localparam int ENDT = (P1 + P2 + P3) * PER;

  logic clk = 1'b0, rst_n = 1'b0, btn = 1'b0;
  logic heat, act;
  logic [1:0] ph;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  heat_profile_seq #(.SLOT_TICKS(SLOT), .PWM_SLOTS(SLOTS), .DEB_TICKS(DEB),
    .PH1_PERIODS(P1), .PH2_PERIODS(P2), .PH3_PERIODS(P3),
    .DUTY1(DU1), .DUTY2(DU2), .DUTY3(DU3)) dut_i (
    .clk(clk), .rst_n(rst_n), .btn_i(btn),
    .heat_en_o(heat), .active_o(act), .phase_o(ph));

  function automatic int exp_phase(int t);
    int p = t / PER;
    if (p < P1) return 1;
    if (p < P1 + P2) return 2;
    return 3;
  endfunction

  function automatic int exp_heat(int t);
    int d;
    case (exp_phase(t))
      1: d = DU1;
      2: d = DU2;
      default: d = DU3;
    endcase
    return (((t / SLOT) % SLOTS) < d) ? 1 : 0;
  endfunction

  task automatic chk(bit ok, string req, int actv, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actv, expv, $time);
    end
  endtask

  task automatic idle_wait(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(act == 1'b0 && heat == 1'b0 && ph == 2'd0, req, {act, heat, ph}, 0);
    end
  endtask

  // R2: press accepted exactly DEB+2 edges after the level change
  task automatic start_press();
    @(negedge clk);
    btn = 1'b1;
    for (int k = 1; k <= DEB + 1; k++) begin
      @(negedge clk);
      if (k == DEB + 1) chk(act == 1'b0, "R2 not yet started", act, 0);
    end
  endtask

  // R4 R5 R6 R7: cycle-by-cycle compare against model
  task automatic run_watch(int rel_t, int abort_t);
    int stop_t = ENDT;
    if (abort_t >= 0) stop_t = abort_t + DEB + 2;
    for (int t = 0; t < stop_t + 3; t++) begin
      int ea, eh, ep;
      @(negedge clk);
      ea = (t < stop_t) ? 1 : 0;
      eh = ea ? exp_heat(t) : 0;
      ep = ea ? exp_phase(t) : 0;
      chk(act == ea[0], (abort_t >= 0 && t >= stop_t) ? "R7 cancel" :
          (t >= ENDT) ? "R6 auto off" : "R5 active", act, ea);
      chk(heat == eh[0], "R4 pwm", heat, eh);
      chk(ph == ep[1:0], "R5 phase", ph, ep);
      if (t == rel_t) btn = 1'b0;
      if (t == abort_t) btn = 1'b1;
    end
  endtask

  task automatic release_idle();
    @(negedge clk);
    btn = 1'b0;
    idle_wait(DEB + 4, "R3 idle after release");
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1729);
    repeat (3) @(negedge clk);
    chk(act == 1'b0 && heat == 1'b0 && ph == 2'd0, "R1 in reset", {act, heat, ph}, 0);
    rst_n = 1'b1;
    idle_wait(5, "R1 after reset");

    // R2: glitch one cycle shorter than debounce window
    @(negedge clk); btn = 1'b1;
    repeat (DEB - 1) @(negedge clk);
    btn = 1'b0;
    idle_wait(3 * DEB, "R2 glitch ignored");

    // full profile with early release
    start_press();
    run_watch(2, -1);
    idle_wait(20, "R6 stays off");

    // R3: hold button through end, no restart
    start_press();
    run_watch(-1, -1);
    idle_wait(3 * DEB, "R3 held no restart");
    release_idle();

    // R7: directed cancel at last possible point and at phase boundary
    start_press();
    run_watch(1, ENDT - DEB - 3);
    release_idle();
    start_press();
    run_watch(1, P1 * PER - DEB - 2);
    release_idle();

    // random cancels mixed with complete runs
    for (int it = 0; it < 8; it++) begin
      int rel, ab, lo, span;
      rel = 1 + int'($urandom % 5);
      lo = rel + DEB + 3;
      span = ENDT - DEB - 3 - lo;
      ab = ($urandom % 3 == 0) ? -1 : lo + int'($urandom % span);
      start_press();
      run_watch(rel, ab);
      if (ab >= 0) release_idle();
      else idle_wait(DEB + 2, "R6 stays off");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule